// File: doc/BRIEF.md
# Serial Boot-Loader Command Sequencer

This block is the control sequencer of a serial boot loader. It starts after a boot-mode entry and reads decoded bytes from a receive stream. It answers on a byte-wide response stream. It drives a request/acknowledge port toward a memory back-end that can erase everything, erase one block, write one word or read one word.

After reset it waits for an external rate-locked signal. It then answers configuration inquiries. When the host ends the inquiry phase, the sequencer erases all user memory on its own and only then enters a command loop. In that loop the host may:

- program 128-byte pages, sent as an address followed by 32 big-endian words, until the host sends the address 0xFFFFFFFF;
- erase single blocks until the host sends the block number 0xFF;
- run a sum check, a blank check, a memory read or a status query.

Every byte is taken with a valid/ready handshake. Multi-byte fields are sent most significant byte first. The memory-operation codes are 0 erase-all, 1 erase-block, 2 write-word and 3 read-word. The response codes are 0x06 acknowledge, 0x80 unknown command, 0x81 refused and 0x82 bad block.

Top module: `boot_cmd_seq`

## Requirements
- R1: While reset is active, and afterwards until rate_locked_i is high, rx_ready_o, tx_valid_o and mem_req_o stay low.
- R2: When rate_locked_i is high, exactly one 0x06 byte is sent, and the block enters the inquiry phase.
- R3: In the inquiry phase the block answers as follows:
  - 0x20 gives 0x06 then MEM_BYTES as 4 bytes;
  - 0x21 gives 0x06 then NUM_BLOCKS as 1 byte;
  - 0x22 gives 0x06 then BASE_ADDR as 4 bytes;
  - 0x23 gives 0x06 then the feature mask 0x0F.
- R4: Before the full erase, a read command 0x52 gets 0x81,0x52 and issues no memory request. Any other code that is not an inquiry code gets 0x80 then that code.
- R5: Code 0x40 in the inquiry phase issues one erase-all request (op 0) with no further host byte. After its acknowledge the block sends 0x06 and enters the command loop. No other memory operation is issued before that erase completes. In the loop, status 0x4F gives 0x06,0x01.
- R6: Code 0x41 gives 0x06. Each 4-byte start address that is not all-ones is followed by 128 data bytes. These produce 32 write requests (op 2) at address+4·i, each carrying the big-endian word i. After the last write the block sends 0x06 and waits for the next address.
- R7: A received word is written to memory before the next byte is taken: rx_ready_o is low while any memory request is pending.
- R8: The address 0xFFFFFFFF gives 0x06, issues no write and returns to the command loop.
- R9: Code 0x42 gives 0x06. Block byte handling:
  - a block number below NUM_BLOCKS issues op 1 with that number as address, then 0x06;
  - any other value except 0xFF gives 0x82 then the number;
  - 0xFF gives 0x06 and returns to the command loop.
- R10: Code 0x50 is followed by a 4-byte address and a 1-byte word count N. It reads N words (op 3) and answers 0x06 then the 8-bit sum of all 4N bytes.
- R11: Code 0x51, with the same operands as 0x50, answers 0x06 then 0x00 if every word read is 0xFFFFFFFF, else 0x01.
- R12: Code 0x52, with the same operands as 0x50, answers 0x06 then the 4N bytes, word by word, MSB first. With N=0 no reads are made: read answers 0x06 alone, and sum and blank answer 0x06,0x00.
- R13: In the command loop any other code, including 0x40 and the inquiry codes, gets 0x80 then that code.
- R14: A pending memory request keeps op, address and data stable until acknowledged. A pending response byte stays unchanged until tx_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_locked_i | input | 1 | Link rate has been matched |
| rx_valid_i | input | 1 | Received byte available |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Byte taken this cycle when valid |
| tx_valid_o | output | 1 | Response byte available |
| tx_data_o | output | 8 | Response byte |
| tx_ready_i | input | 1 | Response byte taken this cycle when valid |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_op_o | output | 2 | Memory operation: 0 erase-all, 1 erase-block, 2 write, 3 read |
| mem_addr_o | output | 32 | Byte address or block number |
| mem_wdata_o | output | 32 | Write word |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read word, valid with mem_ack_i |

## Verification
The hardest case to reach is a read request appearing before the automatic erase, because the only path into the command loop runs through that erase. The stimulus therefore sends read and program codes while still in the inquiry phase and checks that no request reaches the back-end. A second hard case is a host byte arriving while a write is still waiting for its acknowledge. The memory responder delays each acknowledge by a random number of cycles, and the receive path is watched for readiness during every pending request. Erasing a block that holds a freshly programmed page, then blank-checking it, shows that sentinel handling and block addressing agree.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    OP_ERASE_ALL = 2'd0,
    OP_ERASE_BLK = 2'd1,
    OP_WRITE     = 2'd2,
    OP_READ      = 2'd3
  } mem_op_e;

  typedef enum logic [3:0] {
    S_RATE, S_INQ, S_ERASE_ALL, S_CMD, S_PROG_ADDR, S_PROG_DATA, S_PROG_WR,
    S_ERB, S_ERB_WR, S_OPND, S_RD, S_RD_WAIT, S_RESP
  } seq_state_e;

  localparam logic [7:0] RSP_ACK     = 8'h06;
  localparam logic [7:0] RSP_BAD_CMD = 8'h80;
  localparam logic [7:0] RSP_REFUSED = 8'h81;
  localparam logic [7:0] RSP_BAD_BLK = 8'h82;

  localparam logic [7:0] CMD_Q_SIZE   = 8'h20;
  localparam logic [7:0] CMD_Q_MAP    = 8'h21;
  localparam logic [7:0] CMD_Q_BASE   = 8'h22;
  localparam logic [7:0] CMD_Q_FEAT   = 8'h23;
  localparam logic [7:0] CMD_INQ_DONE = 8'h40;
  localparam logic [7:0] CMD_PROG     = 8'h41;
  localparam logic [7:0] CMD_ERASE    = 8'h42;
  localparam logic [7:0] CMD_STATUS   = 8'h4F;
  localparam logic [7:0] CMD_SUM      = 8'h50;
  localparam logic [7:0] CMD_BLANK    = 8'h51;
  localparam logic [7:0] CMD_READ     = 8'h52;

  localparam logic [7:0] BLK_END   = 8'hFF;
  localparam logic [7:0] FEAT_MASK = 8'h0F;

  localparam int RESP_BYTES = 5;
  localparam int RESP_CNT_W = $clog2(RESP_BYTES + 1);
  localparam int RESP_BUF_W = 8 * RESP_BYTES;
endpackage

// File: rtl/boot_resp_shift.sv
module boot_resp_shift
  import boot_seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [RESP_CNT_W-1:0] load_len_i,
  input  logic [RESP_BUF_W-1:0] load_buf_i,
  output logic                  busy_o,
  output logic                  tx_valid_o,
  output logic [7:0]            tx_data_o,
  input  logic                  tx_ready_i
);
  logic [RESP_BUF_W-1:0] buf_q;
  logic [RESP_CNT_W-1:0] left_q;

  // first byte sits in the top lane
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      left_q <= '0;
    end else if (load_i && left_q == '0) begin
      buf_q  <= load_buf_i;
      left_q <= load_len_i;
    end else if (left_q != '0 && tx_ready_i) begin
      buf_q  <= {buf_q[RESP_BUF_W-9:0], 8'h00};
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o     = (left_q != '0);
  assign tx_valid_o = busy_o;
  assign tx_data_o  = buf_q[RESP_BUF_W-1 -: 8];
endmodule

// File: rtl/boot_mem_port.sv
module boot_mem_port
  import boot_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  mem_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output mem_op_e       mem_op_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic          req_q;
  mem_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      op_q    <= OP_ERASE_ALL;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i && !req_q) begin
      req_q   <= 1'b1;
      op_q    <= op_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (req_q && mem_ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign done_o      = req_q & mem_ack_i;
  assign rdata_o     = mem_rdata_i;
  assign mem_req_o   = req_q;
  assign mem_op_o    = op_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
  import boot_seq_pkg::*;
#(
  parameter int          PROG_WORDS = 32,
  parameter int          NUM_BLOCKS = 8,
  parameter logic [31:0] MEM_BYTES  = 32'h0000_1000,
  parameter logic [31:0] BASE_ADDR  = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rate_locked_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic        mem_req_o,
  output logic [1:0]  mem_op_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);
  localparam int IDX_W = 8;
  localparam logic [IDX_W-1:0] LAST_PW = IDX_W'(PROG_WORDS - 1);
  localparam logic [7:0]       NBLK    = 8'(NUM_BLOCKS);

  seq_state_e state_q, state_d, ret_q, ret_d;
  logic             erase_done_q, erase_done_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [31:0]      acc_q, acc_d, acc_nx;
  logic [2:0]       cnt_q, cnt_d;
  logic [31:0]      base_q, base_d, word_addr;
  logic [IDX_W-1:0] idx_q, idx_d, nwords_q, nwords_d;
  logic [7:0]       sum_q, sum_d, rd_sum;
  logic             blank_q, blank_d, blank_nx, rd_last;

  logic                  rsp_load, rsp_busy;
  logic [RESP_CNT_W-1:0] rsp_len;
  logic [RESP_BUF_W-1:0] rsp_buf;

  logic        mp_start, mp_done;
  mem_op_e     mp_op, mp_op_out;
  logic [31:0] mp_wdata, mp_rdata;

  logic rx_take, rx_state;

  function automatic logic [RESP_BUF_W-1:0] rsp2(input logic [7:0] a, input logic [7:0] b);
    return {a, b, 24'h0};
  endfunction

  function automatic logic [RESP_BUF_W-1:0] rsp1w(input logic [7:0] a, input logic [31:0] w);
    return {a, w};
  endfunction

  boot_resp_shift u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rsp_load),
    .load_len_i (rsp_len),
    .load_buf_i (rsp_buf),
    .busy_o     (rsp_busy),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ready_i (tx_ready_i)
  );

  boot_mem_port #(.AW(32), .DW(32)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (mp_start),
    .op_i        (mp_op),
    .addr_i      (word_addr),
    .wdata_i     (mp_wdata),
    .done_o      (mp_done),
    .rdata_o     (mp_rdata),
    .mem_req_o   (mem_req_o),
    .mem_op_o    (mp_op_out),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );
  assign mem_op_o = mp_op_out;

  always_comb begin
    unique case (state_q)
      S_INQ, S_CMD, S_PROG_ADDR, S_PROG_DATA, S_ERB, S_OPND: rx_state = 1'b1;
      default: rx_state = 1'b0;
    endcase
  end

  assign rx_ready_o = rx_state & ~rsp_busy;
  assign rx_take    = rx_valid_i & rx_ready_o;
  assign acc_nx     = {acc_q[23:0], rx_data_i};
  assign word_addr  = base_q + {22'd0, idx_q, 2'b00};
  assign rd_sum     = sum_q + mp_rdata[31:24] + mp_rdata[23:16] + mp_rdata[15:8] + mp_rdata[7:0];
  assign blank_nx   = blank_q & (&mp_rdata);
  assign rd_last    = (idx_q == nwords_q - 8'd1);

  always_comb begin
    state_d      = state_q;
    ret_d        = ret_q;
    erase_done_d = erase_done_q;
    cmd_d        = cmd_q;
    acc_d        = acc_q;
    cnt_d        = cnt_q;
    base_d       = base_q;
    idx_d        = idx_q;
    nwords_d     = nwords_q;
    sum_d        = sum_q;
    blank_d      = blank_q;
    rsp_load     = 1'b0;
    rsp_len      = '0;
    rsp_buf      = '0;
    mp_start     = 1'b0;
    mp_op        = OP_READ;
    mp_wdata     = acc_nx;

    unique case (state_q)
      S_RATE: begin
        if (rate_locked_i) begin
          rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_INQ;
        end
      end

      S_INQ: begin
        if (rx_take) begin
          rsp_load = 1'b1;
          ret_d    = S_INQ;
          case (rx_data_i)
            CMD_Q_SIZE: begin rsp_len = 3'd5; rsp_buf = rsp1w(RSP_ACK, MEM_BYTES); end
            CMD_Q_MAP:  begin rsp_len = 3'd2; rsp_buf = rsp2(RSP_ACK, NBLK); end
            CMD_Q_BASE: begin rsp_len = 3'd5; rsp_buf = rsp1w(RSP_ACK, BASE_ADDR); end
            CMD_Q_FEAT: begin rsp_len = 3'd2; rsp_buf = rsp2(RSP_ACK, FEAT_MASK); end
            CMD_INQ_DONE: begin
              rsp_load = 1'b0;
              mp_start = 1'b1;
              mp_op    = OP_ERASE_ALL;
              state_d  = S_ERASE_ALL;
            end
            CMD_READ: begin rsp_len = 3'd2; rsp_buf = rsp2(RSP_REFUSED, rx_data_i); end
            default:  begin rsp_len = 3'd2; rsp_buf = rsp2(RSP_BAD_CMD, rx_data_i); end
          endcase
        end
      end

      S_ERASE_ALL: begin
        if (mp_done) begin
          erase_done_d = 1'b1;
          rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_CMD;
        end
      end

      S_CMD: begin
        if (rx_take) begin
          cmd_d = rx_data_i;
          cnt_d = '0;
          idx_d = '0;
          acc_d = '0;
          case (rx_data_i)
            CMD_PROG: begin
              rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_PROG_ADDR;
            end
            CMD_ERASE: begin
              rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_ERB;
            end
            CMD_SUM, CMD_BLANK, CMD_READ: state_d = S_OPND;
            CMD_STATUS: begin
              rsp_load = 1'b1; rsp_len = 3'd2; rsp_buf = rsp2(RSP_ACK, {7'd0, erase_done_q}); ret_d = S_CMD;
            end
            default: begin
              rsp_load = 1'b1; rsp_len = 3'd2; rsp_buf = rsp2(RSP_BAD_CMD, rx_data_i); ret_d = S_CMD;
            end
          endcase
        end
      end

      S_PROG_ADDR: begin
        if (rx_take) begin
          acc_d = acc_nx;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd3) begin
            cnt_d = '0;
            if (&acc_nx) begin
              rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_CMD;
            end else begin
              base_d  = acc_nx;
              idx_d   = '0;
              state_d = S_PROG_DATA;
            end
          end
        end
      end

      S_PROG_DATA: begin
        if (rx_take) begin
          acc_d = acc_nx;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd3) begin
            mp_start = 1'b1;
            mp_op    = OP_WRITE;
            state_d  = S_PROG_WR;
          end
        end
      end

      S_PROG_WR: begin
        if (mp_done) begin
          cnt_d = '0;
          if (idx_q == LAST_PW) begin
            idx_d    = '0;
            rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_PROG_ADDR;
          end else begin
            idx_d   = idx_q + 8'd1;
            state_d = S_PROG_DATA;
          end
        end
      end

      S_ERB: begin
        if (rx_take) begin
          if (rx_data_i == BLK_END) begin
            rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_CMD;
          end else if (rx_data_i >= NBLK) begin
            rsp_load = 1'b1; rsp_len = 3'd2; rsp_buf = rsp2(RSP_BAD_BLK, rx_data_i); ret_d = S_ERB;
          end else begin
            base_d  = {24'd0, rx_data_i};
            idx_d   = '0;
            state_d = S_ERB_WR;
          end
        end
      end

      S_ERB_WR: begin
        // start issued here so block number is already in base_q
        mp_start = ~mem_req_o & ~mp_done;
        mp_op    = OP_ERASE_BLK;
        if (mp_done) begin
          rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_ERB;
        end
      end

      S_OPND: begin
        if (rx_take) begin
          acc_d = acc_nx;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd4) begin
            acc_d    = acc_q;
            base_d   = acc_q;
            nwords_d = rx_data_i;
            idx_d    = '0;
            sum_d    = '0;
            blank_d  = 1'b1;
            cnt_d    = '0;
            if (rx_data_i == 8'd0) begin
              rsp_load = 1'b1;
              ret_d    = S_CMD;
              rsp_len  = (cmd_q == CMD_READ) ? 3'd1 : 3'd2;
              rsp_buf  = rsp2(RSP_ACK, 8'h00);
            end else if (cmd_q == CMD_READ) begin
              rsp_load = 1'b1; rsp_len = 3'd1; rsp_buf = rsp2(RSP_ACK, 8'h00); ret_d = S_RD;
            end else begin
              state_d = S_RD;
            end
          end
        end
      end

      S_RD: begin
        mp_start = 1'b1;
        mp_op    = OP_READ;
        state_d  = S_RD_WAIT;
      end

      S_RD_WAIT: begin
        if (mp_done) begin
          sum_d   = rd_sum;
          blank_d = blank_nx;
          idx_d   = idx_q + 8'd1;
          if (cmd_q == CMD_READ) begin
            rsp_load = 1'b1; rsp_len = 3'd4; rsp_buf = {mp_rdata, 8'h00};
            ret_d    = rd_last ? S_CMD : S_RD;
          end else if (rd_last) begin
            rsp_load = 1'b1; rsp_len = 3'd2; ret_d = S_CMD;
            rsp_buf  = rsp2(RSP_ACK, (cmd_q == CMD_SUM) ? rd_sum : {7'd0, ~blank_nx});
          end else begin
            state_d = S_RD;
          end
        end
      end

      S_RESP: begin
        if (!rsp_busy) state_d = ret_q;
      end

      default: state_d = S_RATE;
    endcase

    if (rsp_load) state_d = S_RESP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_RATE;
      ret_q        <= S_RATE;
      erase_done_q <= 1'b0;
      cmd_q        <= '0;
      acc_q        <= '0;
      cnt_q        <= '0;
      base_q       <= '0;
      idx_q        <= '0;
      nwords_q     <= '0;
      sum_q        <= '0;
      blank_q      <= 1'b1;
    end else begin
      state_q      <= state_d;
      ret_q        <= ret_d;
      erase_done_q <= erase_done_d;
      cmd_q        <= cmd_d;
      acc_q        <= acc_d;
      cnt_q        <= cnt_d;
      base_q       <= base_d;
      idx_q        <= idx_d;
      nwords_q     <= nwords_d;
      sum_q        <= sum_d;
      blank_q      <= blank_d;
    end
  end
endmodule

// File: rtl/boot_cmd_seq_chk.sv
module boot_cmd_seq_chk
  import boot_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_ready_i,
  input logic        tx_valid_i,
  input logic [7:0]  tx_data_i,
  input logic        tx_ready_i,
  input logic        mem_req_i,
  input logic        mem_ack_i,
  input logic [1:0]  mem_op_i,
  input logic [31:0] mem_addr_i,
  input logic [31:0] mem_wdata_i,
  input logic        erase_done_i,
  input logic        rate_phase_i
);
  // R1
  rate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_phase_i |-> (!rx_ready_i && !mem_req_i));

  // R7
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> !rx_ready_i);

  // R14
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_ack_i) |=> (mem_req_i && $stable(mem_op_i) && $stable(mem_addr_i) && $stable(mem_wdata_i)));

  // R14
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> (tx_valid_i && $stable(tx_data_i)));

  // R5
  erase_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_op_i != OP_ERASE_ALL) |-> erase_done_i);

  // R4
  no_early_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_op_i == OP_READ) |-> erase_done_i);

  // R5
  erase_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_done_i |=> erase_done_i);
endmodule

bind boot_cmd_seq boot_cmd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_ready_i   (rx_ready_o),
  .tx_valid_i   (tx_valid_o),
  .tx_data_i    (tx_data_o),
  .tx_ready_i   (tx_ready_i),
  .mem_req_i    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_op_i     (mem_op_o),
  .mem_addr_i   (mem_addr_o),
  .mem_wdata_i  (mem_wdata_o),
  .erase_done_i (erase_done_q),
  .rate_phase_i (state_q == boot_seq_pkg::S_RATE)
);

// File: tb/boot_cmd_seq_bench.sv
`timescale 1ns/1ps
module boot_cmd_seq_bench;
  localparam int PW = 32, NB = 8, BLK_WORDS = 128, MEMW = 1024;

  logic clk = 1'b0, rst_n = 1'b0, rate_locked = 1'b0;
  logic rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0] rx_data = '0, tx_data;
  logic mem_req, mem_ack = 1'b0;
  logic [1:0] mem_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, fails = 0;
  logic [31:0] rmem [MEMW];
  logic [31:0] exp_mem [MEMW];
  logic [7:0]  txq [$];
  logic [1:0]  log_op [$];
  logic [31:0] log_addr [$];
  logic [31:0] log_data [$];
  bit overlap_seen = 0, hold_bad = 0;

  boot_cmd_seq u_boot_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .rate_locked_i(rate_locked),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // response sink with random backpressure
  initial begin
    forever begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) txq.push_back(tx_data);
    end
  end

  // memory responder with random acknowledge delay
  initial begin
    for (int i = 0; i < MEMW; i++) rmem[i] = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        logic [1:0] op; logic [31:0] a, d;
        op = mem_op; a = mem_addr; d = mem_wdata;
        if (rx_ready) overlap_seen = 1;
        repeat ($urandom % 3) begin
          @(negedge clk);
          if (mem_req !== 1'b1 || mem_op !== op || mem_addr !== a || mem_wdata !== d) hold_bad = 1;
          if (rx_ready) overlap_seen = 1;
        end
        case (op)
          2'd0: for (int i = 0; i < MEMW; i++) rmem[i] = '1;
          2'd1: for (int i = 0; i < BLK_WORDS; i++) rmem[a[2:0]*BLK_WORDS + i] = '1;
          2'd2: rmem[a[11:2]] = d;
          default: mem_rdata = rmem[a[11:2]];
        endcase
        log_op.push_back(op); log_addr.push_back(a); log_data.push_back(d);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    forever begin
      if (rx_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8]);
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] exp);
    while (txq.size() == 0) @(negedge clk);
    chk(tag, {24'd0, txq.pop_front()}, {24'd0, exp});
  endtask

  task automatic clear_log();
    log_op.delete(); log_addr.delete(); log_data.delete();
  endtask

  function automatic logic [7:0] exp_sum(input int w0, input int n);
    logic [7:0] s = '0;
    for (int i = 0; i < n; i++)
      s = s + exp_mem[w0+i][31:24] + exp_mem[w0+i][23:16] + exp_mem[w0+i][15:8] + exp_mem[w0+i][7:0];
    return s;
  endfunction

  function automatic logic [7:0] exp_blank(input int w0, input int n);
    for (int i = 0; i < n; i++) if (exp_mem[w0+i] != 32'hFFFF_FFFF) return 8'h01;
    return 8'h00;
  endfunction

  task automatic do_query(input logic [7:0] code, input int w0, input int n, input string tag);
    send_byte(code); send_word(w0 * 4); send_byte(8'(n));
    expect_byte(tag, 8'h06);
    if (code == 8'h50) expect_byte(tag, n == 0 ? 8'h00 : exp_sum(w0, n));
    else if (code == 8'h51) expect_byte(tag, n == 0 ? 8'h00 : exp_blank(w0, n));
    else for (int i = 0; i < n; i++)
      for (int k = 3; k >= 0; k--) expect_byte(tag, exp_mem[w0+i][8*k +: 8]);
  endtask

  task automatic program_page(input logic [31:0] addr);
    logic [31:0] w;
    clear_log();
    send_word(addr);
    for (int i = 0; i < PW; i++) begin
      w = $urandom;
      exp_mem[addr[11:2] + i] = w;
      send_word(w);
    end
    expect_byte("R6 page ack", 8'h06);
    chk("R6 write count", log_op.size(), PW);
    for (int i = 0; i < PW && i < log_op.size(); i++) begin
      chk("R6 write op", {30'd0, log_op[i]}, 32'd2);
      chk("R6 write addr", log_addr[i], addr + 4 * i);
      chk("R6 write data", log_data[i], exp_mem[addr[11:2] + i]);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMW; i++) exp_mem[i] = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 reset mem_req", {31'd0, mem_req}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle rx_ready", {31'd0, rx_ready}, 0);
    chk("R1 idle tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 idle no bytes", txq.size(), 0);

    rate_locked = 1'b1;
    expect_byte("R2 lock ack", 8'h06);
    repeat (10) @(negedge clk);
    chk("R2 single ack", txq.size(), 0);

    send_byte(8'h20);
    expect_byte("R3 size", 8'h06); expect_byte("R3 size", 8'h00); expect_byte("R3 size", 8'h00);
    expect_byte("R3 size", 8'h10); expect_byte("R3 size", 8'h00);
    send_byte(8'h21); expect_byte("R3 map", 8'h06); expect_byte("R3 map", 8'(NB));
    send_byte(8'h22);
    for (int i = 0; i < 5; i++) expect_byte("R3 base", i == 0 ? 8'h06 : 8'h00);
    send_byte(8'h23); expect_byte("R3 feat", 8'h06); expect_byte("R3 feat", 8'h0F);

    send_byte(8'h52); expect_byte("R4 refuse", 8'h81); expect_byte("R4 refuse", 8'h52);
    chk("R4 no mem op", log_op.size(), 0);
    send_byte(8'h41); expect_byte("R4 early prog", 8'h80); expect_byte("R4 early prog", 8'h41);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = 8'h60 + 8'($urandom % 8'h90);
      send_byte(b); expect_byte("R4 unknown", 8'h80); expect_byte("R4 unknown", b);
    end

    send_byte(8'h40);
    expect_byte("R5 erase ack", 8'h06);
    chk("R5 one op", log_op.size(), 1);
    if (log_op.size() > 0) chk("R5 erase-all op", {30'd0, log_op[0]}, 0);
    for (int i = 0; i < MEMW; i++) exp_mem[i] = '1;
    send_byte(8'h4F); expect_byte("R5 status", 8'h06); expect_byte("R5 status", 8'h01);

    do_query(8'h51, 64, 4, "R11 blank erased");

    send_byte(8'h41); expect_byte("R6 prep ack", 8'h06);
    program_page(32'h400);
    program_page(32'h800);
    clear_log();
    send_word(32'hFFFF_FFFF);
    expect_byte("R8 end ack", 8'h06);
    chk("R8 no write", log_op.size(), 0);
    chk("R7 no rx during req", {31'd0, overlap_seen}, 0);

    do_query(8'h52, 256, 5, "R12 read");
    do_query(8'h50, 512, 32, "R10 sum page");
    do_query(8'h50, 510, 6, "R10 sum span");
    do_query(8'h51, 256, 2, "R11 blank programmed");

    send_byte(8'h42); expect_byte("R9 prep ack", 8'h06);
    clear_log();
    send_byte(8'h02); expect_byte("R9 blk ack", 8'h06);
    chk("R9 blk op count", log_op.size(), 1);
    if (log_op.size() > 0) begin
      chk("R9 blk op", {30'd0, log_op[0]}, 1);
      chk("R9 blk addr", log_addr[0], 2);
    end
    for (int i = 0; i < BLK_WORDS; i++) exp_mem[2*BLK_WORDS + i] = '1;
    send_byte(8'h09); expect_byte("R9 bad blk", 8'h82); expect_byte("R9 bad blk", 8'h09);
    send_byte(8'hFF); expect_byte("R9 end ack", 8'h06);
    do_query(8'h51, 256, 32, "R9 blank after blk erase");
    do_query(8'h51, 512, 32, "R9 other block kept");

    do_query(8'h52, 10, 0, "R12 zero read");
    do_query(8'h50, 10, 0, "R12 zero sum");
    do_query(8'h51, 10, 0, "R12 zero blank");

    send_byte(8'h77); expect_byte("R13 unknown", 8'h80); expect_byte("R13 unknown", 8'h77);
    send_byte(8'h40); expect_byte("R13 done again", 8'h80); expect_byte("R13 done again", 8'h40);
    send_byte(8'h20); expect_byte("R13 inquiry late", 8'h80); expect_byte("R13 inquiry late", 8'h20);

    for (int it = 0; it < 20; it++) begin
      int kind, w0, n;
      kind = $urandom % 3; w0 = $urandom % 1000; n = 1 + $urandom % 8;
      case (kind)
        0: do_query(8'h50, w0, n, "R10 random sum");
        1: do_query(8'h51, w0, n, "R11 random blank");
        default: do_query(8'h52, w0, n, "R12 random read");
      endcase
    end

    chk("R14 request hold", {31'd0, hold_bad}, 0);
    chk("R7 no rx during req final", {31'd0, overlap_seen}, 0);
    finish_run();
  end
endmodule